// File: doc/BRIEF.md
# Transmit DMA Request Pin Controller

This block owns one active-low output pin that a serial channel can use for one of two jobs. With the function-select bit at 0 the pin is a modem data-terminal-ready line: it is driven low when software sets its DTR bit. With the bit at 1 the pin is a transmit DMA request. It goes low when the transmit buffer empties. In synchronous operation it also goes low once the frame-check sequence that closes a message has been sent.

A request is not dropped when the DMA controller's bus access begins. The read and write strobes are brought into the clock domain through a two-flop synchronizer. When the request is pending, the first rising edge on either strobe starts a short release timer. The pin goes high only when that timer runs out. An edge-triggered DMA controller therefore sees one clean request for each service. A level-sensitive controller cannot issue a second access on a request that has already been answered. Both a channel reset and a hardware reset return the pin to its DTR function.

Top module: `txreq_pin_ctrl`

## Requirements
- R1: While the function-select bit is 0, `req_pin_n` equals the inverse of `dtr_bit` in the same cycle, whatever the event and strobe inputs do.
- R2: While the function-select bit is 1, a high `txbuf_empty_evt` sampled at a rising clock edge drives `req_pin_n` low right after that edge.
- R3: In request mode, a high `crc_sent_evt` asserts the request like R2 only when `sync_mode` is 1. With `sync_mode` at 0 it leaves the pin high.
- R4: With a request pending, a rising edge on `bus_rd_n` or `bus_wr_n` releases the pin. `req_pin_n` stays low through the 6th rising clock edge after the strobe rises and goes high after the 7th: two synchronizer stages, one edge-detect stage, then RELEASE_CYCLES = 4 cycles.
- R5: In request mode with no request pending, strobe edges have no effect and the pin stays high.
- R6: A buffer-empty event that arrives while the release timer runs cancels the release. The pin stays low until a later strobe rise completes a new release.
- R7: A hardware reset (`hw_rst_n` low at a clock edge) clears the function-select bit to 0 and discards any pending request.
- R8: A channel reset (`chan_rst_n` low at a clock edge) clears the function-select bit to 0 and discards any pending request. When request mode is selected again afterwards, the pin is high.
- R9: Events that arrive in DTR mode are not stored. Switching to request mode afterwards leaves the pin high.
- R10: A strobe that falls and stays low does not release a pending request. Only its rise starts the release.
- R11: The function-select bit loads from `cfg_req_mode` at a clock edge where `cfg_we` is 1, and takes effect on the pin after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hw_rst_n | input | 1 | Hardware reset, synchronous, active low |
| chan_rst_n | input | 1 | Channel reset, synchronous, active low |
| cfg_we | input | 1 | Load strobe for the function-select bit |
| cfg_req_mode | input | 1 | New function-select value: 0 = DTR, 1 = DMA request |
| dtr_bit | input | 1 | Software DTR bit |
| sync_mode | input | 1 | Channel is in a synchronous mode |
| txbuf_empty_evt | input | 1 | One-cycle pulse when the transmit buffer becomes empty |
| crc_sent_evt | input | 1 | One-cycle pulse when the end-of-message CRC has been sent |
| bus_rd_n | input | 1 | Asynchronous bus read strobe, active low |
| bus_wr_n | input | 1 | Asynchronous bus write strobe, active low |
| req_pin_n | output | 1 | Shared pin, active low |

## Verification
The DTR function is swept over every combination of `dtr_bit` with the event inputs pulsed. This shows that the pin tracks only the bit and never the request logic. In request mode the sweep covers both trigger sources, both `sync_mode` values and both strobes. Each release is timed cycle by cycle, so an error of one cycle in the synchronizer depth or the timer length shows up as a mismatch. Separate patterns cover an event landing in the middle of a release, a strobe held low for a long time, a strobe with no request pending, and both resets taken while a request is pending. These tell apart cancellation, edge-versus-level detection and the clearing of stored state.

// File: rtl/txreq_pkg.sv
// Package: shared types for the transmit request pin controller.
// Assumes: nothing beyond IEEE 1800-2017.
package txreq_pkg;

    // Request state machine encoding
    typedef enum logic [1:0] {
        RQ_IDLE  = 2'd0,
        RQ_PEND  = 2'd1,
        RQ_DRAIN = 2'd2
    } rq_state_e;

    // Function selected for the shared pin
    typedef enum logic {
        PIN_FN_DTR = 1'b0,
        PIN_FN_REQ = 1'b1
    } pin_fn_e;

endpackage

// File: rtl/strobe_edge_sync.sv
// Module: strobe_edge_sync
// Brings N active-low asynchronous strobes into the clock domain through
// SYNC_STAGES flops. Adds one more flop for edge detection, and flags a
// cycle in which any strobe has risen (access finished).
// Assumes: strobes idle high, and each level lasts longer than a clock period.
module strobe_edge_sync #(
    parameter int N_STROBES   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_STROBES-1:0] strobe_n,
    output logic                 rise_any
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [N_STROBES-1:0] rise_vec;

    genvar g;
    generate
        for (g = 0; g < N_STROBES; g++) begin : g_strobe
            logic [CHAIN_W-1:0] chain_q;

            // Shift the raw strobe through the synchronizer and history flop
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= '1;
                end else begin
                    chain_q <= {chain_q[CHAIN_W-2:0], strobe_n[g]};
                end
            end

            // Rising edge: synchronized level high, previous level low
            assign rise_vec[g] = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
        end
    endgenerate

    // Merge all strobe edges into one release trigger
    assign rise_any = |rise_vec;

endmodule

// File: rtl/pin_fn_reg.sv
// Module: pin_fn_reg
// Holds the function-select bit of the shared pin.
// Assumes: either reset clears it to the DTR function; load has lower priority.
module pin_fn_reg
    import txreq_pkg::*;
(
    input  logic    clk,
    input  logic    hw_rst_n,
    input  logic    chan_rst_n,
    input  logic    load,
    input  logic    load_val,
    output pin_fn_e fn_q
);

    // Load the select bit; both resets force the DTR function
    always_ff @(posedge clk) begin
        if (!hw_rst_n || !chan_rst_n) begin
            fn_q <= PIN_FN_DTR;
        end else if (load) begin
            fn_q <= pin_fn_e'(load_val);
        end
    end

endmodule

// File: rtl/req_fsm.sv
// Module: req_fsm
// Tracks one DMA request. A trigger makes it pending. A strobe rise while
// pending starts a RELEASE_CYCLES timer, and when the timer runs out the
// request is dropped. A trigger during the timer cancels the release.
// Assumes: enable low (DTR function) holds the machine idle and drops triggers.
module req_fsm
    import txreq_pkg::*;
#(
    parameter int RELEASE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic trigger,
    input  logic strobe_rise,
    output logic req_active,
    output logic drain_active
);
    localparam int CNT_W = (RELEASE_CYCLES > 1) ? $clog2(RELEASE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RELEASE_CYCLES - 1);

    rq_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state and timer logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!enable) begin
            state_d = RQ_IDLE;
            cnt_d   = '0;
        end else if (trigger) begin
            state_d = RQ_PEND;
            cnt_d   = '0;
        end else begin
            case (state_q)
                RQ_IDLE: begin
                    cnt_d = '0;
                end
                RQ_PEND: begin
                    if (strobe_rise) begin
                        state_d = RQ_DRAIN;
                        cnt_d   = CNT_LOAD;
                    end
                end
                RQ_DRAIN: begin
                    if (cnt_q == '0) begin
                        state_d = RQ_IDLE;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: begin
                    state_d = RQ_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State and timer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign req_active   = (state_q != RQ_IDLE);
    assign drain_active = (state_q == RQ_DRAIN);

endmodule

// File: rtl/txreq_pin_ctrl.sv
// Module: txreq_pin_ctrl (top)
// Drives a shared active-low pin as either an inverted DTR bit or a transmit
// DMA request. A request is raised by buffer-empty, or by CRC-sent in
// synchronous mode, and is released a fixed time after the servicing strobe rises.
// Assumes: event inputs are one-cycle synchronous pulses; strobes are asynchronous.
module txreq_pin_ctrl
    import txreq_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int RELEASE_CYCLES = 4
) (
    input  logic clk,
    input  logic hw_rst_n,
    input  logic chan_rst_n,
    input  logic cfg_we,
    input  logic cfg_req_mode,
    input  logic dtr_bit,
    input  logic sync_mode,
    input  logic txbuf_empty_evt,
    input  logic crc_sent_evt,
    input  logic bus_rd_n,
    input  logic bus_wr_n,
    output logic req_pin_n
);
    pin_fn_e fn_q;
    logic    strobe_rise;
    logic    trigger;
    logic    fsm_rst_n;
    logic    req_active;
    logic    drain_active;

    // Function-select bit
    pin_fn_reg u_fn (
        .clk        (clk),
        .hw_rst_n   (hw_rst_n),
        .chan_rst_n (chan_rst_n),
        .load       (cfg_we),
        .load_val   (cfg_req_mode),
        .fn_q       (fn_q)
    );

    // Strobe synchronizer and rise detector
    strobe_edge_sync #(
        .N_STROBES   (2),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (hw_rst_n),
        .strobe_n ({bus_wr_n, bus_rd_n}),
        .rise_any (strobe_rise)
    );

    // Request sources: buffer empty, or end-of-message CRC in synchronous mode
    assign trigger   = txbuf_empty_evt | (crc_sent_evt & sync_mode);
    assign fsm_rst_n = hw_rst_n & chan_rst_n;

    // Request tracking and release timer
    req_fsm #(
        .RELEASE_CYCLES (RELEASE_CYCLES)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (fsm_rst_n),
        .enable       (fn_q == PIN_FN_REQ),
        .trigger      (trigger),
        .strobe_rise  (strobe_rise),
        .req_active   (req_active),
        .drain_active (drain_active)
    );

    // Pin function multiplexer
    always_comb begin
        if (fn_q == PIN_FN_REQ) begin
            req_pin_n = ~req_active;
        end else begin
            req_pin_n = ~dtr_bit;
        end
    end

endmodule

// File: rtl/txreq_pin_ctrl_chk.sv
// Module: txreq_pin_ctrl_chk
// Temporal checks on the pin controller, bound into the top module.
// Assumes: hw_rst_n is held low for at least one clock at start-up.
module txreq_pin_ctrl_chk (
    input logic clk,
    input logic hw_rst_n,
    input logic chan_rst_n,
    input logic cfg_we,
    input logic sync_mode,
    input logic txbuf_empty_evt,
    input logic crc_sent_evt,
    input logic req_mode,
    input logic drain_active,
    input logic req_pin_n
);
    logic quiet;
    assign quiet = chan_rst_n && !cfg_we;

    // Buffer-empty in request mode pulls the pin low next cycle
    assert_empty_asserts_R2: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (req_mode && quiet && txbuf_empty_evt) |=> !req_pin_n);

    // CRC-sent outside synchronous mode does not raise an idle request
    assert_crc_async_ignored_R3: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (req_mode && quiet && req_pin_n && crc_sent_evt && !sync_mode && !txbuf_empty_evt)
        |=> req_pin_n);

    // Idle request mode without triggers stays high whatever the strobes do
    assert_idle_stays_high_R5: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (req_mode && quiet && req_pin_n && !txbuf_empty_evt && !(crc_sent_evt && sync_mode))
        |=> req_pin_n);

    // The pin only releases in request mode after the drain phase
    assert_release_after_drain_R4: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (req_mode && $past(req_mode) && $rose(req_pin_n)) |-> $past(drain_active));

    // A trigger during the drain cancels it and keeps the pin low
    assert_drain_cancel_R6: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (req_mode && quiet && drain_active && txbuf_empty_evt) |=> (!req_pin_n && !drain_active));

    // Channel reset returns the pin to its DTR function
    assert_chan_reset_mode_R8: assert property (@(posedge clk) disable iff (!hw_rst_n)
        !chan_rst_n |=> !req_mode);

endmodule

bind txreq_pin_ctrl txreq_pin_ctrl_chk i_chk (
    .clk             (clk),
    .hw_rst_n        (hw_rst_n),
    .chan_rst_n      (chan_rst_n),
    .cfg_we          (cfg_we),
    .sync_mode       (sync_mode),
    .txbuf_empty_evt (txbuf_empty_evt),
    .crc_sent_evt    (crc_sent_evt),
    .req_mode        (fn_q == txreq_pkg::PIN_FN_REQ),
    .drain_active    (drain_active),
    .req_pin_n       (req_pin_n)
);

// File: tb/test_txreq_pin_ctrl.sv
`timescale 1ns/1ps
module test_txreq_pin_ctrl;
    localparam int SYNC_STAGES    = 2;
    localparam int RELEASE_CYCLES = 4;
    // Edges from strobe rise until the pin goes high: sync + detect + timer
    localparam int RELEASE_EDGES  = SYNC_STAGES + 1 + RELEASE_CYCLES;

    logic clk = 1'b0;
    logic hw_rst_n = 1'b0, chan_rst_n = 1'b1, cfg_we = 1'b0, cfg_req_mode = 1'b0;
    logic dtr_bit = 1'b0, sync_mode = 1'b0, txbuf_empty_evt = 1'b0, crc_sent_evt = 1'b0;
    logic bus_rd_n = 1'b1, bus_wr_n = 1'b1;
    logic req_pin_n;
    int   n_cmp = 0, n_bad = 0;

    always #10 clk = ~clk;

    txreq_pin_ctrl #(.SYNC_STAGES(SYNC_STAGES), .RELEASE_CYCLES(RELEASE_CYCLES)) i_txreq_pin_ctrl (
        .clk(clk), .hw_rst_n(hw_rst_n), .chan_rst_n(chan_rst_n), .cfg_we(cfg_we),
        .cfg_req_mode(cfg_req_mode), .dtr_bit(dtr_bit), .sync_mode(sync_mode),
        .txbuf_empty_evt(txbuf_empty_evt), .crc_sent_evt(crc_sent_evt),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .req_pin_n(req_pin_n)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_pin(input logic exp, input string tag);
        #1;
        n_cmp++;
        if (req_pin_n !== exp) begin
            n_bad++;
            $display("FAIL %s: req_pin_n=%b expected %b at %0t", tag, req_pin_n, exp, $time);
        end
    endtask

    task automatic set_mode(input logic m);
        cfg_we = 1'b1; cfg_req_mode = m; step(1); cfg_we = 1'b0;
    endtask

    task automatic pulse_evt(input logic crc);
        if (crc) crc_sent_evt = 1'b1; else txbuf_empty_evt = 1'b1;
        step(1);
        crc_sent_evt = 1'b0; txbuf_empty_evt = 1'b0;
    endtask

    // Lower one strobe for a few cycles, then raise it just after a negedge
    task automatic strobe_low(input logic use_wr, input int len);
        if (use_wr) bus_wr_n = 1'b0; else bus_rd_n = 1'b0;
        step(len);
    endtask

    task automatic strobe_high(input logic use_wr);
        if (use_wr) bus_wr_n = 1'b1; else bus_rd_n = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        step(3);
        // R7: after hardware reset the DTR function is selected
        dtr_bit = 1'b1; expect_pin(1'b0, "R7 reset dtr=1");
        dtr_bit = 1'b0; expect_pin(1'b1, "R7 reset dtr=0");
        hw_rst_n = 1'b1;
        step(4);

        // R1: DTR mode follows ~dtr_bit while events and strobes toggle
        for (int v = 0; v < 8; v++) begin
            dtr_bit = v[0];
            sync_mode = v[1];
            txbuf_empty_evt = v[2]; crc_sent_evt = v[2];
            bus_wr_n = ~v[2];
            step(1);
            expect_pin(~v[0], "R1 dtr follow");
        end
        txbuf_empty_evt = 0; crc_sent_evt = 0; bus_wr_n = 1; dtr_bit = 0;
        step(4);

        // R9 and R11: stale events not kept; mode load takes effect after edge
        dtr_bit = 1'b1;
        pulse_evt(1'b0);
        expect_pin(1'b0, "R11 before load");
        set_mode(1'b1);
        expect_pin(1'b1, "R9 no stale request");

        // R2/R3/R4: sweep trigger source x sync_mode x strobe
        for (int c = 0; c < 8; c++) begin
            logic use_crc, smode, use_wr, fires;
            use_crc = c[0]; smode = c[1]; use_wr = c[2];
            fires = !use_crc || smode;
            sync_mode = smode;
            pulse_evt(use_crc);
            expect_pin(~fires, use_crc ? "R3 crc trigger" : "R2 empty trigger");
            strobe_low(use_wr, 3);
            expect_pin(~fires, "R10 strobe low holds");
            strobe_high(use_wr);
            for (int e = 1; e <= RELEASE_EDGES; e++) begin
                step(1);
                expect_pin((e == RELEASE_EDGES) ? 1'b1 : ~fires,
                           fires ? "R4 release timing" : "R5 strobe without request");
            end
            step(2);
        end

        // R10: strobe held low for a long time does not release
        sync_mode = 1'b0;
        pulse_evt(1'b0);
        strobe_low(1'b0, 20);
        expect_pin(1'b0, "R10 long low");
        strobe_high(1'b0);
        step(RELEASE_EDGES);
        expect_pin(1'b1, "R10 released after rise");

        // R6: trigger during the drain cancels the release
        pulse_evt(1'b0);
        strobe_low(1'b1, 3);
        strobe_high(1'b1);
        step(SYNC_STAGES + 2);
        pulse_evt(1'b0);
        step(RELEASE_EDGES + 4);
        expect_pin(1'b0, "R6 cancelled release");
        strobe_low(1'b1, 3);
        strobe_high(1'b1);
        step(RELEASE_EDGES - 1);
        expect_pin(1'b0, "R6 second release pending");
        step(1);
        expect_pin(1'b1, "R6 second release done");

        // R8: channel reset drops mode and pending request
        pulse_evt(1'b0);
        dtr_bit = 1'b0;
        chan_rst_n = 1'b0; step(1); chan_rst_n = 1'b1;
        expect_pin(1'b1, "R8 dtr function after channel reset");
        set_mode(1'b1);
        expect_pin(1'b1, "R8 pending cleared");

        // R7: hardware reset drops mode and pending request
        pulse_evt(1'b0);
        hw_rst_n = 1'b0; step(1); hw_rst_n = 1'b1;
        dtr_bit = 1'b1;
        expect_pin(1'b0, "R7 dtr function after hw reset");
        set_mode(1'b1);
        expect_pin(1'b1, "R7 pending cleared");

        step(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule